// File: doc/BRIEF.md
# Bit-Plane Lookup Video Databender

This block takes a stream of 8-bit luma samples, marked with line and frame starts, and corrupts them on purpose in a way that can be repeated exactly. It builds the output from two parts. The first part is an error word made by running the pixel's own bit-planes through a programmable 16-entry, 4-input lookup table. The second part is a bent copy of the picture. That copy is shifted sideways by a programmable offset plus a modulation input. Chosen columns freeze on the previous sample. The level is then scaled and wraps around past full scale instead of clipping. The two parts are combined with XOR, and the result is registered out one cycle after the input.

The decision on which columns freeze is a hash of the frame count, the column and a seed register. The seed moves to a new value on every rising edge of a trigger input. With the same configuration, seed history and pixel stream, the block always gives the same picture.

Top module: `lutBender`

## Requirements
- R1: After reset, outValid and outLuma are 0. The lookup table is 0x6996, the shift is 0, the dropout threshold is 0 and the gain is 0x10.
- R2: outValid is pixValid delayed by one clock. outLuma holds the result for the pixel presented in the previous cycle.
- R3: Error bit k is the table entry at index {luma[k+3], luma[k+2], luma[k+1], luma[k]}, with bit numbers taken modulo 8 and luma[k] as the index LSB.
- R4: outLuma is the error word XOR the bent sample.
- R5: The effective shift is the shift register plus shiftMod. Column c takes the input sample of column c minus the shift on the same line. Any column below the shift reads 0.
- R6: The bent sample is bits [11:4] of the selected sample times the 8-bit gain (4 fractional bits). This is a wrap modulo 256, with no saturation.
- R7: A threshold of 0 freezes no column. A threshold of 0xFFFF freezes every column. A frozen column repeats the sample selected for the previous column, and that sample is 0 at column 0.
- R8: For any other threshold, a column freezes when a 16-bit hash of frame count, column and seed is below the threshold. The frame count increments on each pixel marked frameStart. Identical histories give identical output.
- R9: The seed changes only on a rising edge of trigIn. A level held high gives a single change.
- R10: A write with cfgWe loads the register selected by cfgSel: 0 for the table, 1 for the shift (low 5 bits), 2 for the threshold, 3 for the gain (low 8 bits). A pixel marked lineStart or frameStart is column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration register select |
| cfgData | input | 16 | Configuration write data |
| shiftMod | input | 5 | Modulation added to the programmed shift |
| trigIn | input | 1 | Seed re-roll trigger (rising edge) |
| pixValid | input | 1 | Input pixel valid |
| lineStart | input | 1 | Pixel is column 0 of a line |
| frameStart | input | 1 | Pixel starts a new frame |
| pixLuma | input | 8 | Input luma |
| outValid | output | 1 | Output pixel valid |
| outLuma | output | 8 | Databent luma |

## Verification
Seed handling is the hardest part to observe, because the seed is visible only through which columns freeze under an intermediate threshold. The stimulus resets the block, triggers it in different ways, and then replays one identical ramp frame each time. The bench compares whole frames. A single pulse and a held-high trigger must give the same frame. A run with no trigger must differ from a triggered run, and must repeat exactly when done again. The frame counter is covered the same way: a second frame sent without a reset must differ from the first.

// File: rtl/lutBendPkg.sv
package lutBendPkg;
  typedef struct packed {
    logic pixEn;
    logic colFirst;
    logic dropHit;
  } bendStrobe_t;

  typedef enum logic [1:0] {
    SEL_TABLE  = 2'd0,
    SEL_SHIFT  = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_GAIN   = 2'd3
  } cfgSel_e;
endpackage

// File: rtl/lutBendCtrl.sv
module lutBendCtrl
  import lutBendPkg::*;
#(
  parameter int COL_W = 6,
  parameter int SH_W  = 5,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [15:0]      cfgData,
  input  logic             trigIn,
  input  logic             pixValid,
  input  logic             lineStart,
  input  logic             frameStart,
  output bendStrobe_t      strobe,
  output logic [COL_W-1:0] colIdx,
  output logic [15:0]      lutTable,
  output logic [SH_W-1:0]  shiftAmt,
  output logic [PIX_W-1:0] gain,
  output logic [15:0]      threshQ,
  output logic [15:0]      seedVal,
  output logic [15:0]      frameCnt,
  output logic             trigPrev
);
  logic [COL_W-1:0] colCnt;
  logic [15:0]      frameCur;
  logic [15:0]      hashVal;
  logic             isFirst;

  function automatic logic [15:0] mixHash(input logic [15:0] fr, input logic [15:0] col,
                                          input logic [15:0] sd);
    logic [15:0] h;
    h = (fr * 16'h2F1B) ^ (col * 16'h9E37) ^ sd;
    h = h ^ (h >> 7);
    h = h * 16'h5A2D;
    h = h ^ (h >> 8);
    return h;
  endfunction

  function automatic logic [15:0] nextSeed(input logic [15:0] s);
    logic [15:0] t;
    t = s ^ (s << 7);
    t = t ^ (t >> 9);
    t = t ^ (t << 8);
    return t;
  endfunction

  assign isFirst  = lineStart || frameStart;
  assign colIdx   = isFirst ? '0 : colCnt;
  assign frameCur = (pixValid && frameStart) ? frameCnt + 16'd1 : frameCnt;
  assign hashVal  = mixHash(frameCur, 16'(colIdx), seedVal);

  always_comb begin
    strobe.pixEn    = pixValid;
    strobe.colFirst = isFirst;
    strobe.dropHit  = (threshQ == 16'hFFFF) || (hashVal < threshQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt   <= '0;
      frameCnt <= '0;
      seedVal  <= 16'hACE1;
      trigPrev <= 1'b0;
      lutTable <= 16'h6996;
      shiftAmt <= '0;
      threshQ  <= '0;
      gain     <= PIX_W'(16);
    end else begin
      trigPrev <= trigIn;
      if (trigIn && !trigPrev) seedVal <= nextSeed(seedVal);
      if (pixValid) begin
        colCnt   <= colIdx + 1'b1;
        frameCnt <= frameCur;
      end
      if (cfgWe) begin
        case (cfgSel_e'(cfgSel))
          SEL_TABLE:  lutTable <= cfgData;
          SEL_SHIFT:  shiftAmt <= cfgData[SH_W-1:0];
          SEL_THRESH: threshQ  <= cfgData;
          default:    gain     <= cfgData[PIX_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/lutBendPath.sv
module lutBendPath
  import lutBendPkg::*;
#(
  parameter int LINE_W = 64,
  parameter int COL_W  = 6,
  parameter int SH_W   = 5,
  parameter int PIX_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bendStrobe_t      strobe,
  input  logic [COL_W-1:0] colIdx,
  input  logic [PIX_W-1:0] pixLuma,
  input  logic [15:0]      lutTable,
  input  logic [SH_W-1:0]  shiftAmt,
  input  logic [SH_W-1:0]  shiftMod,
  input  logic [PIX_W-1:0] gain,
  output logic             outValid,
  output logic [PIX_W-1:0] outLuma
);
  localparam int FRAC_W = 4;

  logic [PIX_W-1:0]   lineMem [LINE_W];
  logic [COL_W-1:0]   offEff;
  logic [PIX_W-1:0]   shifted;
  logic [PIX_W-1:0]   prevSel;
  logic [PIX_W-1:0]   sampleSel;
  logic [2*PIX_W-1:0] prod;
  logic [PIX_W-1:0]   wrapped;
  logic [PIX_W-1:0]   errWord;

  assign offEff = COL_W'({1'b0, shiftAmt} + {1'b0, shiftMod});

  always_comb begin
    if (offEff == '0)        shifted = pixLuma;
    else if (colIdx < offEff) shifted = '0;
    else                      shifted = lineMem[colIdx - offEff];
  end

  always_comb begin
    if (!strobe.dropHit)      sampleSel = shifted;
    else if (strobe.colFirst) sampleSel = '0;
    else                      sampleSel = prevSel;
  end

  assign prod    = {{PIX_W{1'b0}}, sampleSel} * {{PIX_W{1'b0}}, gain};
  assign wrapped = prod[PIX_W+FRAC_W-1:FRAC_W];

  for (genvar k = 0; k < PIX_W; k++) begin : gErrBit
    logic [3:0] lutIdx;
    assign lutIdx = {pixLuma[(k+3)%PIX_W], pixLuma[(k+2)%PIX_W],
                     pixLuma[(k+1)%PIX_W], pixLuma[k]};
    assign errWord[k] = lutTable[lutIdx];
  end

  always_ff @(posedge clk) begin
    if (strobe.pixEn) lineMem[colIdx] <= pixLuma;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLuma  <= '0;
      prevSel  <= '0;
    end else begin
      outValid <= strobe.pixEn;
      if (strobe.pixEn) begin
        outLuma <= errWord ^ wrapped;
        prevSel <= sampleSel;
      end
    end
  end
endmodule

// File: rtl/lutBender.sv
module lutBender
  import lutBendPkg::*;
#(
  parameter int LINE_W = 64,
  localparam int COL_W = $clog2(LINE_W),
  localparam int SH_W  = COL_W - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [1:0]      cfgSel,
  input  logic [15:0]     cfgData,
  input  logic [SH_W-1:0] shiftMod,
  input  logic            trigIn,
  input  logic            pixValid,
  input  logic            lineStart,
  input  logic            frameStart,
  input  logic [7:0]      pixLuma,
  output logic            outValid,
  output logic [7:0]      outLuma
);
  localparam int PIX_W = 8;

  bendStrobe_t      strobe;
  logic [COL_W-1:0] colIdx;
  logic [15:0]      lutTable;
  logic [SH_W-1:0]  shiftAmt;
  logic [PIX_W-1:0] gain;
  logic [15:0]      threshQ;
  logic [15:0]      seedVal;
  logic [15:0]      frameCnt;
  logic             trigPrev;

  lutBendCtrl #(.COL_W(COL_W), .SH_W(SH_W), .PIX_W(PIX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .trigIn(trigIn), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .strobe(strobe), .colIdx(colIdx),
    .lutTable(lutTable), .shiftAmt(shiftAmt), .gain(gain), .threshQ(threshQ),
    .seedVal(seedVal), .frameCnt(frameCnt), .trigPrev(trigPrev)
  );

  lutBendPath #(.LINE_W(LINE_W), .COL_W(COL_W), .SH_W(SH_W), .PIX_W(PIX_W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colIdx(colIdx), .pixLuma(pixLuma),
    .lutTable(lutTable), .shiftAmt(shiftAmt), .shiftMod(shiftMod), .gain(gain),
    .outValid(outValid), .outLuma(outLuma)
  );
endmodule

// File: rtl/lutBenderChk.sv
module lutBenderChk (
  input logic        clk,
  input logic        rstN,
  input logic        pixValid,
  input logic        frameStart,
  input logic        trigIn,
  input logic        trigPrev,
  input logic        outValid,
  input logic [15:0] frameCnt,
  input logic [15:0] seedVal,
  input logic [15:0] threshQ,
  input logic        dropHit
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);
  // R8
  frame_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && frameStart) |=> frameCnt == $past(frameCnt) + 16'd1);
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pixValid && frameStart) |=> $stable(frameCnt));
  // R9
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trigIn && !trigPrev) |=> $stable(seedVal));
  // R9
  seed_roll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && !trigPrev) |=> seedVal != $past(seedVal));
  // R7
  drop_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (threshQ == 16'hFFFF) |-> dropHit);
  // R7
  drop_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (threshQ == 16'h0000) |-> !dropHit);
endmodule

bind lutBender lutBenderChk chk_i (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
  .trigIn(trigIn), .trigPrev(trigPrev), .outValid(outValid),
  .frameCnt(frameCnt), .seedVal(seedVal), .threshQ(threshQ),
  .dropHit(strobe.dropHit)
);

// File: tb/lutBender_tb_top.sv
`timescale 1ns/1ps
module lutBender_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic [4:0]  shiftMod = '0;
  logic        trigIn = 1'b0;
  logic        pixValid = 1'b0;
  logic        lineStart = 1'b0;
  logic        frameStart = 1'b0;
  logic [7:0]  pixLuma = '0;
  logic        outValid;
  logic [7:0]  outLuma;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] capBuf [64];
  logic [7:0] capA [64];
  logic [7:0] capC [64];
  logic [7:0] gotOut;

  always #2.5 clk = ~clk;

  lutBender dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .shiftMod(shiftMod), .trigIn(trigIn), .pixValid(pixValid),
    .lineStart(lineStart), .frameStart(frameStart), .pixLuma(pixLuma),
    .outValid(outValid), .outLuma(outLuma)
  );

  // {luma, table}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 16'h6996}, {8'hFF, 16'h6996}, {8'h01, 16'h6996}, {8'hA5, 16'h0000},
    {8'h3C, 16'hFFFF}, {8'h81, 16'h8000}, {8'h5A, 16'h0001}, {8'h7E, 16'h1234}
  };

  function automatic logic [7:0] errModel(input logic [7:0] l, input logic [15:0] t);
    logic [7:0] e;
    for (int k = 0; k < 8; k++)
      e[k] = t[{l[(k+3)%8], l[(k+2)%8], l[(k+1)%8], l[k]}];
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    pixValid = 1'b0; lineStart = 1'b0; frameStart = 1'b0; trigIn = 1'b0;
    cfgWe = 1'b0; shiftMod = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [15:0] d);
    cfgWe = 1'b1; cfgSel = sel; cfgData = d;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic sendPix(input logic [7:0] l, input bit ls, input bit fs);
    pixValid = 1'b1; pixLuma = l; lineStart = ls; frameStart = fs;
    @(posedge clk); #1;
    gotOut = outLuma;
    pixValid = 1'b0; lineStart = 1'b0; frameStart = 1'b0;
  endtask

  task automatic runFrame();
    for (int c = 0; c < 64; c++) begin
      sendPix(8'(c * 3 + 7), c == 0, c == 0);
      capBuf[c] = gotOut;
    end
  endtask

  function automatic int diffCount(input logic [7:0] a [64], input logic [7:0] b [64]);
    int n = 0;
    for (int i = 0; i < 64; i++) if (a[i] != b[i]) n++;
    return n;
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset outputs
    check(outValid == 1'b0 && outLuma == 8'h00, "R1 reset outputs", {outValid, outLuma}, 0);
    // R1 default table and gain, R4 combine
    sendPix(8'h01, 1'b1, 1'b0);
    check(gotOut == (errModel(8'h01, 16'h6996) ^ 8'h01), "R1 default table", gotOut,
          errModel(8'h01, 16'h6996) ^ 8'h01);
    // R2 valid drops one cycle after input
    @(posedge clk); #1;
    check(outValid == 1'b0, "R2 valid latency", outValid, 0);

    // R3 R4 vector table
    for (int v = 0; v < 8; v++) begin
      logic [7:0]  l;
      logic [15:0] t;
      logic [7:0]  e;
      l = VEC[v][23:16];
      t = VEC[v][15:0];
      e = errModel(l, t) ^ l;
      cfgWrite(2'd0, t);
      sendPix(l, 1'b1, 1'b0);
      check(outValid == 1'b1, "R2 valid with pixel", outValid, 1);
      check(gotOut == e, "R3 R4 lut vector", gotOut, e);
    end

    // R5 R10 shift with modulation and edge zero fill
    doReset();
    cfgWrite(2'd0, 16'h0000);
    cfgWrite(2'd1, 16'h0003);
    shiftMod = 5'd2;
    begin
      int bad = 0;
      for (int c = 0; c < 16; c++) begin
        logic [7:0] e;
        e = (c < 5) ? 8'h00 : 8'(c - 4);
        sendPix(8'(c + 1), c == 0, 1'b0);
        if (gotOut != e) bad++;
        if (c == 4) check(gotOut == 8'h00, "R5 edge zero", gotOut, 0);
        if (c == 9) check(gotOut == 8'h05, "R10 shift register write", gotOut, 5);
      end
      check(bad == 0, "R5 shifted line", bad, 0);
    end

    // R6 level wrap
    doReset();
    cfgWrite(2'd0, 16'h0000);
    cfgWrite(2'd3, 16'h0030);
    sendPix(8'h60, 1'b1, 1'b0);
    check(gotOut == 8'h20, "R6 wrap past full scale", gotOut, 8'h20);
    sendPix(8'h40, 1'b0, 1'b0);
    check(gotOut == 8'hC0, "R6 scale in range", gotOut, 8'hC0);
    sendPix(8'h05, 1'b0, 1'b0);
    check(gotOut == 8'h0F, "R6 scale small", gotOut, 8'h0F);

    // R7 full dropout freezes zero from column 0, then none
    doReset();
    cfgWrite(2'd0, 16'h0000);
    cfgWrite(2'd2, 16'hFFFF);
    begin
      int bad = 0;
      for (int c = 0; c < 8; c++) begin
        sendPix(8'(c + 10), c == 0, 1'b0);
        if (gotOut != 8'h00) bad++;
      end
      check(bad == 0, "R7 all columns frozen", bad, 0);
    end
    cfgWrite(2'd2, 16'h0000);
    begin
      int bad = 0;
      for (int c = 0; c < 8; c++) begin
        sendPix(8'(c + 10), c == 0, 1'b0);
        if (gotOut != 8'(c + 10)) bad++;
      end
      check(bad == 0, "R7 no column frozen", bad, 0);
    end

    // R9 single pulse trigger
    doReset();
    cfgWrite(2'd2, 16'h8000);
    trigIn = 1'b1; @(posedge clk); #1; trigIn = 1'b0;
    runFrame();
    capA = capBuf;
    // R9 held trigger gives one re-roll
    doReset();
    cfgWrite(2'd2, 16'h8000);
    trigIn = 1'b1; repeat (6) @(posedge clk); #1; trigIn = 1'b0;
    runFrame();
    check(diffCount(capBuf, capA) == 0, "R9 held trigger one edge", diffCount(capBuf, capA), 0);
    // R9 no trigger differs
    doReset();
    cfgWrite(2'd2, 16'h8000);
    runFrame();
    capC = capBuf;
    check(diffCount(capC, capA) != 0, "R9 seed change alters frame", diffCount(capC, capA), 1);
    // R8 frame counter changes the pattern
    runFrame();
    check(diffCount(capBuf, capC) != 0, "R8 next frame differs", diffCount(capBuf, capC), 1);
    // R8 reproducible
    doReset();
    cfgWrite(2'd2, 16'h8000);
    runFrame();
    check(diffCount(capBuf, capC) == 0, "R8 repeat identical", diffCount(capBuf, capC), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule